// File: doc/BRIEF.md
# Three-Operand ALU with Rotate and Right Shifts

This block is the combinational arithmetic and logic unit of a small 16-bit datapath. It takes three data operands, A, B and C, and a four-bit operation code. It returns a 16-bit result, a zero flag and a negative flag in the same cycle. Beyond the usual two-input add and subtract, it can accumulate into a third operand. C is normally the destination register's old value, and the block computes C+A+B or C−A−B in one pass.

Bitwise AND, OR and XOR cover all bits. Right rotates and right shifts move operand A by an amount taken from the low four bits of B. A pass-through code forwards B unchanged, so a value already formed elsewhere, such as a load-upper immediate, can reach the result bus. Arithmetic wraps modulo 2^16, and no carry or overflow is reported.

Top module: `alu3_top`

## Requirements
- R1: Code 0 gives A+B and code 1 gives A−B, both truncated to 16 bits.
- R2: Code 2 gives C+A+B and code 3 gives C−A−B, both truncated to 16 bits.
- R3: Code 4 gives A AND B, code 5 gives A OR B and code 6 gives A XOR B, bit by bit over all 16 bits.
- R4: Code 7 rotates A right by B[3:0] places. Bits leaving bit 0 re-enter at bit 15.
- R5: Code 8 shifts A right logically by B[3:0] places and fills the vacated high bits with 0.
- R6: Code 9 shifts A right arithmetically by B[3:0] places and fills the vacated high bits with A[15].
- R7: For codes 7, 8 and 9, B[15:4] has no effect on the result.
- R8: For codes 7, 8 and 9, an amount of 0 returns A unchanged.
- R9: Code 10 returns B unchanged.
- R10: Codes 11 to 15 return 0.
- R11: zero_o is 1 exactly when the result is 0x0000.
- R12: neg_o equals result bit 15.
- R13: Arithmetic wraps without error, so 0xFFFF+1 gives 0x0000 and 0−1 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Operand A; the value that is shifted or rotated |
| b_i | input | 16 | Operand B; second operand, shift amount, or pass value |
| c_i | input | 16 | Operand C; accumulator for the three-input codes |
| op_i | input | 4 | Operation code |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result bit 15 |

## Verification
The bench sets the high bits of B during shifts. A unit that decoded the full B would shift everything out or rotate by the wrong amount. It uses shift amounts of 0 and 15: a barrel stage wired to the wrong amount bit, or a rotate that drops the wrapped bits, shows up there. It also pits negative against positive A under the arithmetic shift, which exposes a zero fill where a sign fill belongs. Finally, it pushes sums and differences across the wrap point and feeds in the undefined codes. That catches a swapped operand order in the three-input subtract, a lost carry, or stale data on the unused codes.

// File: rtl/alu3_pkg.sv
package alu3_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADD3 = 4'd2,
        OP_SUB3 = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_ROR  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9,
        OP_PASS = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        AR_ADD2 = 2'd0,
        AR_SUB2 = 2'd1,
        AR_ADD3 = 2'd2,
        AR_SUB3 = 2'd3
    } arith_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_kind_e;

    typedef enum logic [1:0] {
        SH_ROR = 2'd0,
        SH_SRL = 2'd1,
        SH_SRA = 2'd2
    } shift_kind_e;

    function automatic logic is_shift(input logic [3:0] op);
        return (op == OP_ROR) || (op == OP_SRL) || (op == OP_SRA);
    endfunction

endpackage

// File: rtl/alu3_arith.sv
module alu3_arith
    import alu3_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    input  arith_kind_e      kind_i,
    output logic [WIDTH-1:0] y_o
);
    logic [WIDTH-1:0] sum2, dif2, sum3, dif3;

    assign sum2 = a_i + b_i;
    assign dif2 = a_i - b_i;
    assign sum3 = c_i + sum2;
    assign dif3 = c_i - sum2;

    always_comb begin
        unique case (kind_i)
            AR_ADD2: y_o = sum2;
            AR_SUB2: y_o = dif2;
            AR_ADD3: y_o = sum3;
            default: y_o = dif3;
        endcase
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i, kind_i}) && kind_i == AR_SUB3) begin
            p_sub3_inverse_r2: assert (y_o + a_i + b_i == c_i)
                else $error("R2 three-input subtract does not invert");
        end
        if (!$isunknown({a_i, b_i, kind_i}) && kind_i == AR_SUB2) begin
            p_sub_inverse_r1: assert (y_o + b_i == a_i)
                else $error("R1 subtract does not invert");
        end
    end
endmodule

// File: rtl/alu3_logic.sv
module alu3_logic
    import alu3_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic_kind_e      kind_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        unique case (kind_i)
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            default: y_o = a_i ^ b_i;
        endcase
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, kind_i}) && kind_i == LG_AND) begin
            p_and_subset_r3: assert ((y_o & ~a_i) == '0 && (y_o & ~b_i) == '0)
                else $error("R3 AND result has bits outside operands");
        end
        if (!$isunknown({a_i, b_i, kind_i}) && kind_i == LG_OR) begin
            p_or_superset_r3: assert ((a_i & ~y_o) == '0)
                else $error("R3 OR result lost bits of A");
        end
    end
endmodule

// File: rtl/alu3_shift.sv
module alu3_shift
    import alu3_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0]         a_i,
    input  logic [$clog2(WIDTH)-1:0] amt_i,
    input  shift_kind_e              kind_i,
    output logic [WIDTH-1:0]         y_o
);
    localparam int STAGES = $clog2(WIDTH);

    logic [WIDTH-1:0] stage [0:STAGES];
    logic             fill;
    logic             rot;

    assign fill     = (kind_i == SH_SRA) ? a_i[WIDTH-1] : 1'b0;
    assign rot      = (kind_i == SH_ROR);
    assign stage[0] = a_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = !amt_i[k] ? stage[k] :
                            rot ? {stage[k][STEP-1:0], stage[k][WIDTH-1:STEP]}
                                : {{STEP{fill}}, stage[k][WIDTH-1:STEP]};
    end

    assign y_o = stage[STAGES];

    always_comb begin
        if (!$isunknown({a_i, amt_i, kind_i})) begin
            if (amt_i == '0) begin
                p_zero_amount_r8: assert (y_o == a_i)
                    else $error("R8 zero amount changed operand");
            end
            if (kind_i == SH_ROR) begin
                p_rotate_keeps_ones_r4: assert ($countones(y_o) == $countones(a_i))
                    else $error("R4 rotate lost bits");
            end
            if (kind_i == SH_SRL && amt_i != '0) begin
                p_srl_top_zero_r5: assert (y_o[WIDTH-1] == 1'b0)
                    else $error("R5 logical shift top bit not zero");
            end
            if (kind_i == SH_SRA) begin
                p_sra_sign_r6: assert (y_o[WIDTH-1] == a_i[WIDTH-1])
                    else $error("R6 arithmetic shift lost sign");
            end
        end
    end
endmodule

// File: rtl/alu3_top.sv
module alu3_top
    import alu3_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] c_i,
    input  logic [3:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             neg_o
);
    localparam int AMT_W = $clog2(WIDTH);

    arith_kind_e      ar_kind;
    logic_kind_e      lg_kind;
    shift_kind_e      sh_kind;
    logic [WIDTH-1:0] ar_y, lg_y, sh_y;

    always_comb begin
        ar_kind = AR_ADD2;
        lg_kind = LG_AND;
        sh_kind = SH_ROR;
        unique case (op_i)
            OP_SUB:  ar_kind = AR_SUB2;
            OP_ADD3: ar_kind = AR_ADD3;
            OP_SUB3: ar_kind = AR_SUB3;
            OP_OR:   lg_kind = LG_OR;
            OP_XOR:  lg_kind = LG_XOR;
            OP_SRL:  sh_kind = SH_SRL;
            OP_SRA:  sh_kind = SH_SRA;
            default: ;
        endcase
    end

    alu3_arith #(.WIDTH(WIDTH)) u_arith (
        .a_i(a_i), .b_i(b_i), .c_i(c_i), .kind_i(ar_kind), .y_o(ar_y)
    );

    alu3_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i(a_i), .b_i(b_i), .kind_i(lg_kind), .y_o(lg_y)
    );

    alu3_shift #(.WIDTH(WIDTH)) u_shift (
        .a_i(a_i), .amt_i(b_i[AMT_W-1:0]), .kind_i(sh_kind), .y_o(sh_y)
    );

    always_comb begin
        unique case (op_i)
            OP_ADD, OP_SUB, OP_ADD3, OP_SUB3: result_o = ar_y;
            OP_AND, OP_OR, OP_XOR:            result_o = lg_y;
            OP_ROR, OP_SRL, OP_SRA:           result_o = sh_y;
            OP_PASS:                          result_o = b_i;
            default:                          result_o = '0;
        endcase
    end

    assign zero_o = ~|result_o;
    assign neg_o  = result_o[WIDTH-1];

    always_comb begin
        if (!$isunknown({a_i, b_i, c_i, op_i})) begin
            if (op_i == OP_ADD3) begin
                p_add3_sum_r2: assert (result_o - c_i - b_i == a_i)
                    else $error("R2 three-input add wrong");
            end
            if (op_i == OP_ADD) begin
                p_add_wrap_r13: assert (result_o - b_i == a_i)
                    else $error("R13 add does not wrap consistently");
            end
            if (op_i > OP_PASS) begin
                p_unused_zero_r10: assert (result_o == '0 && zero_o)
                    else $error("R10 unused code gave data");
            end
            if (op_i == OP_PASS) begin
                p_pass_r9: assert (result_o == b_i)
                    else $error("R9 pass-through altered B");
            end
            p_flags_exclusive_r11: assert (!(zero_o && neg_o))
                else $error("R11 zero and negative both set");
            if (zero_o) begin
                p_zero_means_r12: assert (result_o[WIDTH-1] == 1'b0)
                    else $error("R12 negative set on zero result");
            end
        end
    end
endmodule

// File: tb/test_alu3_top.sv
module test_alu3_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a, b, c;
    logic [3:0]  op;
    logic [15:0] result;
    logic        zero, neg;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 0;

    always #4 clk = ~clk;

    alu3_top i_alu3_top (
        .a_i(a), .b_i(b), .c_i(c), .op_i(op),
        .result_o(result), .zero_o(zero), .neg_o(neg)
    );

    function automatic logic [15:0] model(input logic [3:0] o, input logic [15:0] x,
                                          input logic [15:0] y, input logic [15:0] z);
        logic [3:0]  n;
        logic [15:0] r;
        n = y[3:0];
        case (o)
            4'd0:  r = x + y;
            4'd1:  r = x - y;
            4'd2:  r = z + x + y;
            4'd3:  r = z - x - y;
            4'd4:  r = x & y;
            4'd5:  r = x | y;
            4'd6:  r = x ^ y;
            4'd7:  r = (n == 0) ? x : ((x >> n) | (x << (5'd16 - {1'b0, n})));
            4'd8:  r = x >> n;
            4'd9:  r = $signed(x) >>> n;
            4'd10: r = y;
            default: r = 16'h0000;
        endcase
        return r;
    endfunction

    function automatic string tag(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R1";
            4'd2, 4'd3: return "R2";
            4'd4, 4'd5, 4'd6: return "R3";
            4'd7: return "R4";
            4'd8: return "R5";
            4'd9: return "R6";
            4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic run(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic [15:0] z, input string req);
        logic [15:0] exp;
        @(negedge clk);
        op = o; a = x; b = y; c = z;
        #2;
        exp = model(o, x, y, z);
        n_checks++;
        if (result !== exp || zero !== (exp == 16'h0) || neg !== exp[15]) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h c=%h: actual r=%h z=%b n=%b expected r=%h z=%b n=%b",
                     req, o, x, y, z, result, zero, neg, exp, exp == 16'h0, exp[15]);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; c = '0; op = 4'd0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R11: reset-time inputs of zero give a zero result
        run(4'd0, 16'h0000, 16'h0000, 16'h0000, "R11");
        // R13: wrap around
        run(4'd0, 16'hFFFF, 16'h0001, 16'h0000, "R13");
        run(4'd1, 16'h0000, 16'h0001, 16'h0000, "R13");
        // R1 and R2 directed
        run(4'd1, 16'h1234, 16'h0034, 16'h0000, "R1");
        run(4'd2, 16'h0010, 16'h0020, 16'h0100, "R2");
        run(4'd3, 16'h0010, 16'h0020, 16'h0100, "R2");
        run(4'd3, 16'h0001, 16'h0001, 16'h0001, "R2");
        // R3 directed
        run(4'd4, 16'hF0F0, 16'hFF00, 16'h0, "R3");
        run(4'd5, 16'hF0F0, 16'h0F0F, 16'h0, "R3");
        run(4'd6, 16'hAAAA, 16'hFFFF, 16'h0, "R3");
        // R4 rotate wrap
        run(4'd7, 16'h0001, 16'h0001, 16'h0, "R4");
        run(4'd7, 16'h8001, 16'h000F, 16'h0, "R4");
        // R5 and R6 fill
        run(4'd8, 16'h8000, 16'h000F, 16'h0, "R5");
        run(4'd9, 16'h8000, 16'h000F, 16'h0, "R6");
        run(4'd9, 16'h7FFF, 16'h0004, 16'h0, "R6");
        // R7: high bits of B ignored by shifts
        run(4'd7, 16'h1234, 16'hFFF4, 16'h0, "R7");
        run(4'd8, 16'hBEEF, 16'h8010, 16'h0, "R7");
        run(4'd9, 16'h8421, 16'h1003, 16'h0, "R7");
        // R8: zero amount
        run(4'd7, 16'hC3A5, 16'h0000, 16'h0, "R8");
        run(4'd8, 16'hC3A5, 16'hFFF0, 16'h0, "R8");
        run(4'd9, 16'hC3A5, 16'h0010, 16'h0, "R8");
        // R9 pass, R10 unused
        run(4'd10, 16'h1111, 16'hAB00, 16'h2222, "R9");
        for (int k = 11; k < 16; k++) run(4'(k), 16'hFFFF, 16'hFFFF, 16'hFFFF, "R10");
        // R12: negative flag
        run(4'd0, 16'h7FFF, 16'h0001, 16'h0, "R12");
        // random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] o;
            o = 4'($urandom % 16);
            run(o, 16'($urandom), 16'($urandom), 16'($urandom), tag(o));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule